// File: doc/BRIEF.md
# Register and Memory Move Execution Unit

This unit carries out one move instruction at a time for a 32-bit processor with sixteen general registers. Each instruction arrives as a fixed 16-bit word with a one-cycle valid strobe, together with the program counter of that instruction. The unit decodes the word and reads its source registers. It forms an effective address for the addressing mode in use, issues at most one byte, word or longword access on a request/ready memory port, and writes the destination register and any address register the mode changes.

The addressing modes are: an 8-bit signed immediate; register copy; register indirect; pre-decrement stores; post-increment loads; base plus a displacement scaled by the operand size; base plus R0; and PC-relative loads. A word that matches none of the supported encodings raises a one-cycle illegal flag and changes nothing. Any other instruction ends with a one-cycle done flag. The caller presents the next instruction only after done or illegal has been seen.

Top module: `mov_exec_unit`

## Requirements
- R1: After a synchronous reset, all sixteen registers read as zero and done, illegal and mem_req are low.
- R2: An opcode with bits 15:12 = 1110 writes the sign-extended 8-bit field in bits 7:0 into the register named by bits 11:8.
- R3: Bits 15:12 = 0110 with bits 3:0 = 0011 copies the register in bits 7:4 to the register in bits 11:8, with no memory request. For this and every other instruction that has no memory access (immediate, copy, illegal), done or illegal is high in the second cycle after the cycle in which insn_valid was sampled.
- R4: Addresses are byte addresses, and byte lane k of the 32-bit data bus is bits 8k+7:8k. A byte access enables lane addr[1:0] (one-hot mem_be). A word access enables 0011 when addr[1] is 0 and 1100 when it is 1. A longword access enables 1111. Store data is repeated in every lane: a byte four times, a word twice. Register-indirect forms are 0110 nnnn mmmm 00ss (load from Rm into Rn) and 0010 nnnn mmmm 00ss (store Rm to Rn), where ss is 00 for byte, 01 for word and 10 for longword.
- R5: Byte and word loads are sign-extended to 32 bits from the selected lane or lanes. Longword loads are written unchanged.
- R6: 0010 nnnn mmmm 01ss stores Rm at the address Rn minus the size in bytes (1, 2 or 4), and leaves that address in Rn. The stored value is Rm as it was before the instruction, even when m equals n.
- R7: 0110 nnnn mmmm 01ss loads from the address in Rm into Rn, then sets Rm to its old value plus the size in bytes. When n equals m, the loaded value is what the register holds afterwards.
- R8: 1000 0000 nnnn dddd and 1000 0001 nnnn dddd store R0 as a byte or word at Rn + d or Rn + 2d. 1000 0100 mmmm dddd and 1000 0101 mmmm dddd load a byte or word from Rm + d or Rm + 2d into R0, sign-extended. The 4-bit d is zero-extended.
- R9: 0001 nnnn mmmm dddd stores longword Rm at Rn + 4d. 0101 nnnn mmmm dddd loads the longword at Rm + 4d into Rn.
- R10: 0000 nnnn mmmm 0100 and 0000 nnnn mmmm 0101 store the byte or word of Rm at R0 + Rn.
- R11: 1001 nnnn dddddddd loads a word, sign-extended, from (pc + 4) + 2d. 1101 nnnn dddddddd loads a longword from ((pc + 4) with bits 1:0 cleared) + 4d. The 8-bit d is zero-extended.
- R12: Any opcode not listed in R2 to R11 gives a one-cycle illegal pulse, no done pulse, no memory request and no register write.
- R13: While a request waits for mem_ready, mem_req, mem_addr, mem_be, mem_wdata and mem_we stay unchanged. The register writes take effect on the edge where mem_ready is sampled high, and done is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction strobe, sampled only while the unit is idle |
| insn | input | 16 | Instruction word |
| pc | input | 32 | Address of the instruction, sampled together with insn |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | High for a store, low for a load |
| mem_addr | output | 32 | Byte address of the access |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Store data, repeated across lanes |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Completes the pending access |
| done | output | 1 | One-cycle pulse when a legal instruction finishes |
| illegal | output | 1 | One-cycle pulse for an unsupported opcode |

## Verification
The bench covers the aliasing corners. These are pre-decrement with m equal to n, where a design that reads Rm after the update stores the wrong value, and post-increment with n equal to m, where the wrong write priority leaves the incremented address in place of the loaded data. It puts byte and word accesses on every lane offset, with source values whose sign bits differ. A wrong lane select or a zero extension there shows up as a corrupted register when the register is stored back out. PC-relative longword loads use PC values whose bits 1:0 are not zero, so a missing alignment mask moves the address. Memory stalls of varying length check that the request holds still and that done follows mem_ready. Illegal words that sit next to legal encodings must leave every register untouched.

// File: rtl/movx_pkg.sv
package movx_pkg;
    localparam int XLEN   = 32;
    localparam int ILEN   = 16;
    localparam int NREG   = 16;
    localparam int RIDX   = $clog2(NREG);
    localparam int NLANE  = XLEN / 8;

    // operand size code doubles as the displacement shift amount
    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2} opsz_e;
    typedef enum logic [1:0] {K_IMM, K_COPY, K_LOAD, K_STORE} kind_e;
    typedef enum logic [1:0] {BA_REG, BA_PCW, BA_PCL} base_e;
    typedef enum logic [1:0] {OF_DISP, OF_R0, OF_PRE} off_e;

    typedef struct packed {
        logic             legal;
        kind_e            kind;
        opsz_e            size;
        base_e            base;
        off_e             off;
        logic             upd;    // base register is rewritten
        logic [RIDX-1:0]  rd;     // destination
        logic [RIDX-1:0]  rs;     // data source
        logic [RIDX-1:0]  rb;     // address base
        logic [XLEN-1:0]  disp;   // already scaled
        logic [XLEN-1:0]  imm;
    } dec_t;

    function automatic logic [XLEN-1:0] size_bytes(opsz_e s);
        return XLEN'(1) << s;
    endfunction

    function automatic logic [XLEN-1:0] sext8(logic [7:0] v);
        return {{(XLEN-8){v[7]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext16(logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/movx_decode.sv
module movx_decode
    import movx_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output dec_t            dec
);
    logic [3:0]      f_hi, f_n, f_m, f_lo;
    logic [XLEN-1:0] raw;

    assign f_hi = insn[15:12];
    assign f_n  = insn[11:8];
    assign f_m  = insn[7:4];
    assign f_lo = insn[3:0];

    always_comb begin
        dec       = '0;
        dec.kind  = K_IMM;
        dec.size  = SZ_L;
        dec.base  = BA_REG;
        dec.off   = OF_DISP;
        raw       = '0;
        unique case (f_hi)
            4'hE: begin                                     // R2
                dec.legal = 1'b1;
                dec.rd    = f_n;
                dec.imm   = sext8(insn[7:0]);
            end
            4'h9, 4'hD: begin                               // R11
                dec.legal = 1'b1;
                dec.kind  = K_LOAD;
                dec.size  = f_hi[2] ? SZ_L : SZ_W;
                dec.base  = f_hi[2] ? BA_PCL : BA_PCW;
                dec.rd    = f_n;
                raw       = XLEN'(insn[7:0]);
            end
            4'h6: begin
                if (f_lo == 4'b0011) begin                  // R3
                    dec.legal = 1'b1;
                    dec.kind  = K_COPY;
                    dec.rs    = f_m;
                    dec.rd    = f_n;
                end else if (!f_lo[3] && f_lo[1:0] != 2'b11) begin   // R4 R7
                    dec.legal = 1'b1;
                    dec.kind  = K_LOAD;
                    dec.size  = opsz_e'(f_lo[1:0]);
                    dec.rb    = f_m;
                    dec.rd    = f_n;
                    dec.upd   = f_lo[2];
                end
            end
            4'h2: begin
                if (!f_lo[3] && f_lo[1:0] != 2'b11) begin   // R4 R6
                    dec.legal = 1'b1;
                    dec.kind  = K_STORE;
                    dec.size  = opsz_e'(f_lo[1:0]);
                    dec.rs    = f_m;
                    dec.rb    = f_n;
                    dec.off   = f_lo[2] ? OF_PRE : OF_DISP;
                    dec.upd   = f_lo[2];
                end
            end
            4'h8: begin                                     // R8
                if (f_n[3:2] == 2'b00 || f_n[3:2] == 2'b01) begin
                    if (f_n[1] == 1'b0 && (f_n[3] == 1'b0)) begin
                        dec.legal = 1'b1;
                        dec.kind  = f_n[2] ? K_LOAD : K_STORE;
                        dec.size  = opsz_e'({1'b0, f_n[0]});
                        dec.rb    = f_m;
                        dec.rs    = '0;
                        dec.rd    = '0;
                        raw       = XLEN'(f_lo);
                    end
                end
            end
            4'h1, 4'h5: begin                               // R9
                dec.legal = 1'b1;
                dec.kind  = f_hi[2] ? K_LOAD : K_STORE;
                dec.size  = SZ_L;
                dec.rd    = f_n;
                dec.rs    = f_m;
                dec.rb    = f_hi[2] ? f_m : f_n;
                raw       = XLEN'(f_lo);
            end
            4'h0: begin                                     // R10
                if (f_lo[3:1] == 3'b010) begin
                    dec.legal = 1'b1;
                    dec.kind  = K_STORE;
                    dec.size  = opsz_e'({1'b0, f_lo[0]});
                    dec.rs    = f_m;
                    dec.rb    = f_n;
                    dec.off   = OF_R0;
                end
            end
            default: ;                                      // R12
        endcase
        dec.disp = raw << dec.size;
    end
endmodule

// File: rtl/movx_regfile.sv
module movx_regfile
    import movx_pkg::*;
#(
    parameter int NRP = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NRP-1:0][RIDX-1:0]  rd_idx,
    output logic [NRP-1:0][XLEN-1:0]  rd_data,
    // port A: result write, wins over port B on the same index
    input  logic                      wa_en,
    input  logic [RIDX-1:0]           wa_idx,
    input  logic [XLEN-1:0]           wa_data,
    // port B: address register update
    input  logic                      wb_en,
    input  logic [RIDX-1:0]           wb_idx,
    input  logic [XLEN-1:0]           wb_data
);
    logic [XLEN-1:0] regs [NREG];

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        assign rd_data[p] = regs[rd_idx[p]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (wb_en) regs[wb_idx] <= wb_data;
            if (wa_en) regs[wa_idx] <= wa_data;   // later assignment gives port A priority (R7)
        end
    end
endmodule

// File: rtl/movx_agu.sv
module movx_agu
    import movx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  base_e           base,
    input  off_e            off,
    input  opsz_e           size,
    input  logic [XLEN-1:0] disp,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] r0_val,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] upd_val
);
    logic [XLEN-1:0] pc_ahead, b_term, o_term, step;

    assign pc_ahead = pc + XLEN'(4);
    assign step     = size_bytes(size);

    always_comb begin
        unique case (base)
            BA_PCW:  b_term = pc_ahead;
            BA_PCL:  b_term = pc_ahead & ~XLEN'(3);   // R11
            default: b_term = base_val;
        endcase
        unique case (off)
            OF_R0:   o_term = r0_val;                 // R10
            OF_PRE:  o_term = '0 - step;              // R6
            default: o_term = disp;
        endcase
    end

    assign addr    = b_term + o_term;
    assign upd_val = (off == OF_PRE) ? addr : base_val + step;   // R6 R7

    // R11: aligned base plus a scaled displacement stays longword aligned
    assert_pcl_align_R11: assert property (@(posedge clk) disable iff (rst)
        (base == BA_PCL) |-> (addr[1:0] == 2'b00));
endmodule

// File: rtl/movx_lane.sv
module movx_lane
    import movx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  opsz_e             size,
    input  logic [1:0]        lane,
    input  logic [XLEN-1:0]   st_val,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   wdata,
    output logic [NLANE-1:0]  be,
    output logic [XLEN-1:0]   ld_val
);
    logic [7:0]  ld_byte;
    logic [15:0] ld_half;

    assign ld_byte = rdata[8*lane +: 8];
    assign ld_half = lane[1] ? rdata[31:16] : rdata[15:0];

    always_comb begin
        unique case (size)
            SZ_B: begin
                wdata  = {NLANE{st_val[7:0]}};
                be     = NLANE'(1) << lane;
                ld_val = sext8(ld_byte);              // R5
            end
            SZ_W: begin
                wdata  = {(NLANE/2){st_val[15:0]}};
                be     = lane[1] ? 4'b1100 : 4'b0011;
                ld_val = sext16(ld_half);             // R5
            end
            default: begin
                wdata  = st_val;
                be     = '1;
                ld_val = rdata;
            end
        endcase
    end

    // R4: enable pattern width follows the operand size
    assert_be_shape_R4: assert property (@(posedge clk) disable iff (rst)
        active |-> ((size == SZ_B) ? $onehot(be) :
                    (size == SZ_W) ? ($countones(be) == 2) : (be == 4'hF)));
endmodule

// File: rtl/mov_exec_unit.sv
module mov_exec_unit
    import movx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid,
    input  logic [ILEN-1:0]   insn,
    input  logic [XLEN-1:0]   pc,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [NLANE-1:0]  mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic              illegal
);
    typedef enum logic {ST_IDLE, ST_EXEC} st_e;

    st_e             state;
    logic [ILEN-1:0] insn_q;
    logic [XLEN-1:0] pc_q;
    dec_t            dec;
    logic            is_mem, finish;

    logic [2:0][RIDX-1:0] rf_idx;
    logic [2:0][XLEN-1:0] rf_val;
    logic [XLEN-1:0]      addr, upd_val, ld_val, res_val;
    logic                 wa_en, wb_en;

    movx_decode u_dec (.insn(insn_q), .dec(dec));

    assign rf_idx[0] = dec.rb;
    assign rf_idx[1] = dec.rs;
    assign rf_idx[2] = '0;

    movx_regfile #(.NRP(3)) u_rf (
        .clk(clk), .rst(rst),
        .rd_idx(rf_idx), .rd_data(rf_val),
        .wa_en(wa_en), .wa_idx(dec.rd), .wa_data(res_val),
        .wb_en(wb_en), .wb_idx(dec.rb), .wb_data(upd_val)
    );

    movx_agu u_agu (
        .clk(clk), .rst(rst),
        .base(dec.base), .off(dec.off), .size(dec.size), .disp(dec.disp),
        .base_val(rf_val[0]), .r0_val(rf_val[2]), .pc(pc_q),
        .addr(addr), .upd_val(upd_val)
    );

    movx_lane u_lane (
        .clk(clk), .rst(rst), .active(mem_req),
        .size(dec.size), .lane(addr[1:0]), .st_val(rf_val[1]),
        .rdata(mem_rdata), .wdata(mem_wdata), .be(mem_be), .ld_val(ld_val)
    );

    assign is_mem   = dec.legal && (dec.kind == K_LOAD || dec.kind == K_STORE);
    assign mem_req  = (state == ST_EXEC) && is_mem;
    assign mem_we   = dec.kind == K_STORE;
    assign mem_addr = addr;
    assign finish   = (state == ST_EXEC) && (!is_mem || mem_ready);

    assign wa_en = finish && dec.legal && dec.kind != K_STORE;
    assign wb_en = finish && dec.legal && dec.upd;

    always_comb begin
        unique case (dec.kind)
            K_IMM:   res_val = dec.imm;
            K_COPY:  res_val = rf_val[1];
            default: res_val = ld_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            insn_q  <= '0;
            pc_q    <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= finish && dec.legal;
            illegal <= finish && !dec.legal;
            if (state == ST_IDLE) begin
                if (insn_valid) begin
                    insn_q <= insn;
                    pc_q   <= pc;
                    state  <= ST_EXEC;
                end
            end else if (finish) begin
                state <= ST_IDLE;
            end
        end
    end

    // R13: a stalled request keeps every field steady
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)
                                     && $stable(mem_wdata) && $stable(mem_we)));

    // R13: completion of a memory instruction follows an accepted access
    assert_done_after_ready_R13: assert property (@(posedge clk) disable iff (rst)
        (done && $past(mem_req)) |-> $past(mem_ready));

    // R12: the two completion flags never coincide
    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(done && illegal));

    // R12: an illegal opcode never reached the memory port
    assert_illegal_no_mem_R12: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !$past(mem_req));

    // R3: nothing completes in the cycle right after acceptance
    assert_accept_gap_R3: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && insn_valid) |=> (!done && !illegal));
endmodule

// File: tb/mov_exec_unit_tb_top.sv
module mov_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [31:0] pc = '0;
    logic        mem_req, mem_we, done, illegal;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    mov_exec_unit dut_i (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .pc(pc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done), .illegal(illegal)
    );

    typedef struct {
        int          typ;     // 0 memory access, 1 done, 2 illegal
        bit          we;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] rf [16];
    int          n_cmp = 0, n_bad = 0;
    int          cyc = 0, issue_t = 0, acc_cnt = 0, wait_left = 0;
    bit          in_acc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tally(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---- independent memory and lane model ----
    function automatic logic [31:0] memword(input logic [31:0] a);
        return {a[7:0] ^ 8'hF1, a[7:0] + 8'h37, ~a[7:0], a[7:0] ^ 8'h5A};
    endfunction
    function automatic logic [3:0] lanes(input int sz, input logic [31:0] a);
        if (sz == 0) return 4'b0001 << a[1:0];
        if (sz == 1) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction
    function automatic logic [31:0] loadval(input int sz, input logic [31:0] a);
        logic [31:0] w = memword({a[31:2], 2'b00});
        logic [7:0]  b = w >> (8 * a[1:0]);
        logic [15:0] h = a[1] ? w[31:16] : w[15:0];
        if (sz == 0) return {{24{b[7]}}, b};
        if (sz == 1) return {{16{h[15]}}, h};
        return w;
    endfunction
    function automatic logic [31:0] mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic push_mem(input bit we, input logic [31:0] a, input int sz,
                            input logic [31:0] d, input string req);
        exp_t e;
        e.typ = 0; e.we = we; e.addr = a; e.be = lanes(sz, a); e.req = req;
        e.wdata = (sz == 0) ? {4{d[7:0]}} : (sz == 1) ? {2{d[15:0]}} : d;
        sb.push_back(e);
    endtask
    task automatic push_end(input int typ, input string req);
        exp_t e;
        e.typ = typ; e.we = 0; e.addr = '0; e.be = '0; e.wdata = '0; e.req = req;
        sb.push_back(e);
    endtask
    task automatic do_load(input int sz, input logic [31:0] a, input logic [3:0] dst,
                           input string req);
        push_mem(0, a, sz, '0, req);
        rf[dst] = loadval(sz, a);
    endtask

    // ---- reference model built from the requirements ----
    task automatic model(input logic [15:0] op, input logic [31:0] pcv, input string req);
        logic [3:0]  n = op[11:8], m = op[7:4], lo = op[3:0];
        logic [31:0] a, v, dv;
        int          sz = int'(lo[1:0]);
        bit          bad = 0;
        case (op[15:12])
            4'hE: rf[n] = {{24{op[7]}}, op[7:0]};
            4'h9: do_load(1, pcv + 4 + {23'd0, op[7:0], 1'b0}, n, req);
            4'hD: do_load(2, ((pcv + 4) & ~32'd3) + {22'd0, op[7:0], 2'b00}, n, req);
            4'h6: begin
                if (lo == 4'h3) rf[n] = rf[m];
                else if (!lo[3] && lo[1:0] != 2'b11) begin
                    a = rf[m];
                    v = loadval(sz, a);
                    push_mem(0, a, sz, '0, req);
                    if (lo[2]) rf[m] = rf[m] + (32'd1 << sz);
                    rf[n] = v;
                end else bad = 1;
            end
            4'h2: begin
                if (!lo[3] && lo[1:0] != 2'b11) begin
                    dv = rf[m];
                    if (lo[2]) rf[n] = rf[n] - (32'd1 << sz);
                    push_mem(1, rf[n], sz, dv, req);
                end else bad = 1;
            end
            4'h8: begin
                case (op[11:8])
                    4'h0: push_mem(1, rf[m] + {28'd0, lo}, 0, rf[0], req);
                    4'h1: push_mem(1, rf[m] + {27'd0, lo, 1'b0}, 1, rf[0], req);
                    4'h4: do_load(0, rf[m] + {28'd0, lo}, 4'd0, req);
                    4'h5: do_load(1, rf[m] + {27'd0, lo, 1'b0}, 4'd0, req);
                    default: bad = 1;
                endcase
            end
            4'h1: push_mem(1, rf[n] + {26'd0, lo, 2'b00}, 2, rf[m], req);
            4'h5: do_load(2, rf[m] + {26'd0, lo, 2'b00}, n, req);
            4'h0: begin
                if (lo == 4'h4 || lo == 4'h5) push_mem(1, rf[0] + rf[n], int'(lo[0]), rf[m], req);
                else bad = 1;
            end
            default: bad = 1;
        endcase
        push_end(bad ? 2 : 1, req);
    endtask

    // ---- driver ----
    task automatic issue(input logic [15:0] op, input logic [31:0] pcv, input string req);
        model(op, pcv, req);
        insn = op; pc = pcv; insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0; insn = 16'hFFFF; pc = 32'hDEAD_BEEF;
        issue_t = cyc;
        while (sb.size() != 0) @(negedge clk);
    endtask
    task automatic run(input logic [15:0] op, input string req);
        issue(op, 32'h0000_2000, req);
    endtask
    // store register k through base R15, exposing its value on the memory port
    task automatic dump(input logic [3:0] k, input string req);
        run({4'h2, 4'hF, k, 4'h2}, req);
    endtask

    // ---- monitor: pops expectations as results appear ----
    always @(negedge clk) begin
        bit rp;
        exp_t e;
        if (!rst) begin
            rp = mem_ready;
            if (done || illegal) begin
                if (sb.size() == 0) tally(0, "R12", "unexpected completion", {30'd0, illegal, done}, 32'd0);
                else begin
                    e = sb.pop_front();
                    tally((e.typ == 1 && done && !illegal) || (e.typ == 2 && illegal && !done),
                          e.req, "completion kind", {30'd0, illegal, done}, e.typ);
                    if (in_acc || rp)
                        tally(rp, "R13", "done one cycle after ready", {31'd0, rp}, 32'd1);
                    else
                        tally(cyc - issue_t == 1, "R3", "no-memory latency", cyc - issue_t, 32'd1);
                end
            end
            mem_ready = 1'b0;
            if (mem_req && !rp) begin
                if (!in_acc) begin
                    in_acc = 1;
                    wait_left = acc_cnt % 3;
                    acc_cnt++;
                end
                if (wait_left == 0) begin
                    if (sb.size() == 0 || sb[0].typ != 0)
                        tally(0, "R12", "unexpected memory request", mem_addr, 32'd0);
                    else begin
                        e = sb.pop_front();
                        tally(mem_we == e.we, e.req, "direction", {31'd0, mem_we}, {31'd0, e.we});
                        tally(mem_addr == e.addr, e.req, "address", mem_addr, e.addr);
                        tally(mem_be == e.be, e.req, "byte enables", {28'd0, mem_be}, {28'd0, e.be});
                        if (e.we)
                            tally((mem_wdata & mask(e.be)) == (e.wdata & mask(e.be)),
                                  e.req, "store data", mem_wdata, e.wdata);
                    end
                    mem_rdata = memword({mem_addr[31:2], 2'b00});
                    mem_ready = 1'b1;
                end else wait_left--;
            end else if (!mem_req) begin
                in_acc = (rp && !done) ? in_acc : in_acc;
            end
            if (done || illegal) in_acc = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R13 watchdog actual=hung expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tally(!done && !illegal && !mem_req, "R1", "idle outputs after reset",
              {29'd0, mem_req, illegal, done}, 32'd0);
        for (int k = 0; k < 16; k++) dump(4'(k), "R1");

        // R2 immediates
        run(16'hEF70, "R2"); run(16'hE140, "R2"); run(16'hE280, "R2"); run(16'hE37F, "R2");
        dump(2, "R2"); dump(3, "R2");
        // R3 register copy
        run(16'h6423, "R3"); dump(4, "R3");
        // R4 R5 indirect loads across lanes
        run(16'h6510, "R5"); run(16'h6611, "R5"); run(16'h6712, "R5");
        dump(5, "R5"); dump(6, "R5"); dump(7, "R5");
        run(16'hE143, "R4"); run(16'h6510, "R5"); dump(5, "R5");
        run(16'hE142, "R4"); run(16'h6611, "R5"); dump(6, "R5");
        run(16'hE141, "R4"); run(16'h6510, "R5"); dump(5, "R5");
        // R4 indirect stores
        run(16'h2120, "R4"); run(16'h2121, "R4"); run(16'h2122, "R4");
        run(16'hE142, "R4"); run(16'h2130, "R4"); run(16'h2131, "R4");
        // R6 pre-decrement stores
        run(16'hE140, "R6"); run(16'h2134, "R6"); run(16'h2135, "R6"); run(16'h2136, "R6");
        dump(1, "R6");
        run(16'h2116, "R6"); dump(1, "R6");
        // R7 post-increment loads
        run(16'hE140, "R7"); run(16'h6514, "R7"); run(16'h6615, "R7"); run(16'h6716, "R7");
        dump(1, "R7"); dump(5, "R7"); dump(6, "R7"); dump(7, "R7");
        run(16'h6116, "R7"); dump(1, "R7");
        // R8 R0 with scaled displacement
        run(16'hE150, "R8"); run(16'hE0A5, "R8");
        run(16'h8013, "R8"); run(16'h8112, "R8");
        run(16'h8417, "R8"); dump(0, "R8");
        run(16'h8513, "R8"); dump(0, "R8");
        // R9 longword displacement
        run(16'h1123, "R9"); run(16'h5317, "R9"); dump(3, "R9");
        // R10 R0-indexed stores
        run(16'hE004, "R10"); run(16'h0124, "R10"); run(16'h0125, "R10");
        run(16'hE003, "R10"); run(16'h0124, "R10");
        // R11 PC-relative loads
        issue(16'h9805, 32'h0000_1002, "R11"); dump(8, "R11");
        issue(16'h98F0, 32'h0000_1000, "R11"); dump(8, "R11");
        issue(16'hD905, 32'h0000_1002, "R11"); dump(9, "R11");
        issue(16'hD905, 32'h0000_1000, "R11"); dump(9, "R11");
        issue(16'hD9FF, 32'h0000_1006, "R11"); dump(9, "R11");
        // R12 unsupported words leave all state alone
        run(16'h0126, "R12"); run(16'h6327, "R12"); run(16'h2123, "R12");
        run(16'h8212, "R12"); run(16'hF000, "R12"); run(16'h3000, "R12");
        run(16'h0000, "R12"); run(16'h212B, "R12");
        for (int k = 0; k < 16; k++) dump(4'(k), "R12");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule